// File: doc/BRIEF.md
# NAND Command and Address Latch

This block sits at the input side of a NAND flash device model. On every write strobe it looks at the 8-bit I/O bus and decides what the byte is. While chip enable (active low) is asserted, a byte is a command when the command-latch line is high. It is an address byte when only the address-latch line is high. The block holds the current command, an address register assembled from the address bytes, a count of address cycles and a starting column offset. It emits a one-cycle execute pulse, tagged with the command code, when a command is ready for the data-path and status logic.

Several read command codes are aliases that select a starting column. The number of address cycles that launches a read or program setup depends on two static configuration inputs: page geometry and capacity class. In large-page mode, some second-phase bytes are swallowed, or only reset the column part of the address.

Top module: `nand_cmd_addr_latch`

## Requirements
- R1: After reset, `cmd_q` is 0x00, `addr_q` is 0, `addr_cnt` is 0, `col_off` is 0 and `exec_pulse` is low.
- R2: A strobe while `ce_n` is high, or a strobe with neither `cle` nor `ale` high, changes no output register and raises no execute pulse.
- R3: Command 0x00 stores 0x00 with `col_off` 0. Command 0x01 stores 0x00 with `col_off` 0x100. Command 0x50 stores 0x00 with `col_off` equal to the page size: 512 when `cfg_large_page` is 0, 2048 when it is 1.
- R4: With `cfg_large_page` = 1, a command byte 0x30 received while `cmd_q` is 0x00 is ignored entirely. With any other current command, 0x30 is latched as an ordinary command.
- R5: With `cfg_large_page` = 1, command byte 0x05 clears `addr_q[15:0]` and `addr_cnt`. It leaves `cmd_q` unchanged and raises no pulse.
- R6: Address byte n (counting from 0) is written to `addr_q[8n+7:8n]`, and each address byte adds one to `addr_cnt`. Bytes beyond the fifth do not change `addr_q`. `addr_cnt` saturates at 7.
- R7: With `cfg_x16` = 1, the whole address is shifted left by one bit right after the second address byte is stored.
- R8: When `cmd_q` is 0x90, the first address byte raises an execute pulse tagged 0x90.
- R9: When `cmd_q` is 0x00 or 0x80, an execute pulse tagged with that command is raised on the 3rd address byte (`cfg_large_page` = 0). It comes on the 4th byte (large page, `cfg_big_cap` = 0) or on the 5th byte (large page, `cfg_big_cap` = 1).
- R10: Commands 0x70, 0x10, 0x60, 0xD0, 0x35, 0xE0 and 0xFF raise an execute pulse tagged with the code in the cycle after the strobe. Every latched command clears `addr_cnt`, except 0xE0, which keeps it.
- R11: On 0xD0, `addr_q` keeps only its lowest `addr_cnt` bytes. It is then shifted left by 16 bits in large-page mode and by 8 bits otherwise.
- R12: Command 0xFF returns `cmd_q`, `addr_q`, `col_off` and `addr_cnt` to their reset values.
- R13: A strobe with `cle` and `ale` both high is a command cycle only. `exec_pulse` is high for exactly one cycle, and only right after an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_large_page | input | 1 | Static: 2048-byte page geometry when 1, 512-byte when 0 |
| cfg_big_cap | input | 1 | Static: capacity of 2 Gbit or more |
| cfg_x16 | input | 1 | Static: 16-bit data bus |
| wr_stb | input | 1 | Write strobe, one cycle per bus byte |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Byte is a command |
| ale | input | 1 | Byte is an address |
| io_in | input | 8 | Bus byte |
| cmd_q | output | 8 | Current command |
| addr_q | output | 40 | Assembled address |
| addr_cnt | output | 3 | Address cycles seen |
| col_off | output | 12 | Starting column offset |
| exec_pulse | output | 1 | One-cycle execute request |
| exec_cmd | output | 8 | Command tagged on the last execute request |

## Verification
The properties assume that the three configuration inputs change only while no strobe is in flight. They also assume that `io_in`, `cle`, `ale` and `ce_n` are known whenever `wr_stb` is high. The bench changes configuration only right after a reset, before the first strobe of a scenario. It drives every strobe input on the falling edge, so the latch sees settled values. Each strobe lasts exactly one clock, which matches the assumption that one strobe carries one byte.

// File: rtl/nand_cmd_addr_latch.sv
module nand_cmd_addr_latch #(
  parameter int ADDR_BYTES = 5,
  parameter int SMALL_PAGE = 512,
  parameter int LARGE_PAGE = 2048,
  parameter int CNT_W      = 3,
  localparam int ADDR_W    = ADDR_BYTES * 8,
  localparam int OFF_W     = $clog2(LARGE_PAGE) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_large_page,
  input  logic              cfg_big_cap,
  input  logic              cfg_x16,
  input  logic              wr_stb,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic [7:0]        io_in,
  output logic [7:0]        cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  addr_cnt,
  output logic [OFF_W-1:0]  col_off,
  output logic              exec_pulse,
  output logic [7:0]        exec_cmd
);

  logic              take, cmd_cyc, adr_cyc, swallow, col_rst, imm, rw_cmd;
  logic [7:0]        mapped;
  logic [ADDR_W-1:0] kept, erase_addr;
  logic [7:0]        n_cmd, n_ecmd;
  logic [ADDR_W-1:0] n_addr;
  logic [CNT_W-1:0]  n_cnt;
  logic [OFF_W-1:0]  n_off;
  logic              n_exec;

  assign take    = wr_stb & ~ce_n;
  assign cmd_cyc = take & cle;
  assign adr_cyc = take & ~cle & ale;
  assign swallow = cfg_large_page & (cmd_q == 8'h00) & (io_in == 8'h30);
  assign col_rst = cfg_large_page & (io_in == 8'h05);
  assign mapped  = (io_in == 8'h01 || io_in == 8'h50) ? 8'h00 : io_in;
  assign imm     = (io_in == 8'h70) | (io_in == 8'h10) | (io_in == 8'h60) |
                   (io_in == 8'hD0) | (io_in == 8'h35) | (io_in == 8'hE0) |
                   (io_in == 8'hFF);
  assign rw_cmd  = (cmd_q == 8'h00) | (cmd_q == 8'h80);

  always_comb begin
    kept = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (i < int'(addr_cnt)) kept[8*i +: 8] = addr_q[8*i +: 8];
  end

  assign erase_addr = cfg_large_page ? (kept << 16) : (kept << 8);

  always_comb begin
    n_cmd  = cmd_q;
    n_addr = addr_q;
    n_cnt  = addr_cnt;
    n_off  = col_off;
    n_exec = 1'b0;
    n_ecmd = exec_cmd;
    if (cmd_cyc && !swallow) begin
      if (col_rst) begin
        n_addr[15:0] = '0;
        n_cnt        = '0;
      end else begin
        n_cmd = mapped;
        if (io_in == 8'h00)      n_off = '0;
        else if (io_in == 8'h01) n_off = OFF_W'(256);
        else if (io_in == 8'h50) n_off = cfg_large_page ? OFF_W'(LARGE_PAGE) : OFF_W'(SMALL_PAGE);
        if (io_in != 8'hE0) n_cnt = '0;
        if (imm) begin
          n_exec = 1'b1;
          n_ecmd = io_in;
        end
        if (io_in == 8'hD0) n_addr = erase_addr;
        if (io_in == 8'hFF) begin
          n_cmd  = '0;
          n_addr = '0;
          n_off  = '0;
        end
      end
    end else if (adr_cyc && addr_cnt != '1) begin
      if (int'(addr_cnt) < ADDR_BYTES) n_addr[8*int'(addr_cnt) +: 8] = io_in;
      n_cnt = addr_cnt + 1'b1;
      if (n_cnt == CNT_W'(2) && cfg_x16) n_addr = n_addr << 1;
      if ((n_cnt == CNT_W'(1) && cmd_q == 8'h90) ||
          (rw_cmd && ((!cfg_large_page && n_cnt == CNT_W'(3)) ||
                      (cfg_large_page && !cfg_big_cap && n_cnt == CNT_W'(4)) ||
                      (cfg_large_page && cfg_big_cap && n_cnt == CNT_W'(5))))) begin
        n_exec = 1'b1;
        n_ecmd = cmd_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      addr_q     <= '0;
      addr_cnt   <= '0;
      col_off    <= '0;
      exec_pulse <= 1'b0;
      exec_cmd   <= '0;
    end else begin
      cmd_q      <= n_cmd;
      addr_q     <= n_addr;
      addr_cnt   <= n_cnt;
      col_off    <= n_off;
      exec_pulse <= n_exec;
      exec_cmd   <= n_ecmd;
    end
  end

endmodule

// File: rtl/nand_cmd_addr_latch_chk.sv
module nand_cmd_addr_latch_chk #(
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 3,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_large_page,
  input logic              wr_stb,
  input logic              ce_n,
  input logic              cle,
  input logic              ale,
  input logic [7:0]        io_in,
  input logic [7:0]        cmd_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [CNT_W-1:0]  addr_cnt,
  input logic [OFF_W-1:0]  col_off,
  input logic              exec_pulse,
  input logic [7:0]        exec_cmd
);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && !ce_n && (cle || ale)) |=>
      $stable(cmd_q) && $stable(addr_q) && $stable(addr_cnt) && $stable(col_off) && !exec_pulse);

  p_exec_origin_r13: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse |-> $past(wr_stb && !ce_n && (cle || ale)));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !ce_n && !cle && ale && addr_cnt != '1) |=> addr_cnt == $past(addr_cnt) + 1'b1);

  p_swallow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !ce_n && cle && cfg_large_page && cmd_q == 8'h00 && io_in == 8'h30) |=>
      $stable(cmd_q) && $stable(addr_q) && $stable(addr_cnt) && !exec_pulse);

  p_col_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !ce_n && cle && cfg_large_page && io_in == 8'h05) |=>
      addr_cnt == '0 && addr_q[15:0] == '0 && $stable(cmd_q) && !exec_pulse);

  p_status_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !ce_n && cle && io_in == 8'h70) |=> exec_pulse && exec_cmd == 8'h70 && addr_cnt == '0);

  p_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !ce_n && cle && io_in == 8'h01) |=> cmd_q == 8'h00 && col_off == OFF_W'(256));

endmodule

bind nand_cmd_addr_latch nand_cmd_addr_latch_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_large_page(cfg_large_page), .wr_stb(wr_stb),
  .ce_n(ce_n), .cle(cle), .ale(ale), .io_in(io_in), .cmd_q(cmd_q),
  .addr_q(addr_q), .addr_cnt(addr_cnt), .col_off(col_off),
  .exec_pulse(exec_pulse), .exec_cmd(exec_cmd)
);

// File: tb/tb_nand_cmd_addr_latch.sv
`timescale 1ns/1ps
module tb_nand_cmd_addr_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_large_page = 1'b0, cfg_big_cap = 1'b0, cfg_x16 = 1'b0;
  logic        wr_stb = 1'b0, ce_n = 1'b1, cle = 1'b0, ale = 1'b0;
  logic [7:0]  io_in = '0;
  logic [7:0]  cmd_q, exec_cmd;
  logic [39:0] addr_q;
  logic [2:0]  addr_cnt;
  logic [11:0] col_off;
  logic        exec_pulse;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nand_cmd_addr_latch dut (
    .clk(clk), .rst_n(rst_n), .cfg_large_page(cfg_large_page), .cfg_big_cap(cfg_big_cap),
    .cfg_x16(cfg_x16), .wr_stb(wr_stb), .ce_n(ce_n), .cle(cle), .ale(ale), .io_in(io_in),
    .cmd_q(cmd_q), .addr_q(addr_q), .addr_cnt(addr_cnt), .col_off(col_off),
    .exec_pulse(exec_pulse), .exec_cmd(exec_cmd)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic lp, input logic bc, input logic x16);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_large_page = lp; cfg_big_cap = bc; cfg_x16 = x16;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic put(input logic c, input logic a, input logic n, input logic [7:0] b);
    @(negedge clk);
    cle = c; ale = a; ce_n = n; io_in = b; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; cle = 1'b0; ale = 1'b0; ce_n = 1'b1;
  endtask

  task automatic cmd(input logic [7:0] b); put(1'b1, 1'b0, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b); put(1'b0, 1'b1, 1'b0, b); endtask

  task automatic t_reset;
    do_reset(0, 0, 0);
    chk("R1 cmd", cmd_q, 0);
    chk("R1 addr", addr_q, 0);
    chk("R1 cnt", addr_cnt, 0);
    chk("R1 off", col_off, 0);
    chk("R1 exec", exec_pulse, 0);
  endtask

  task automatic t_aliases;
    do_reset(0, 0, 0);
    cmd(8'h01);
    chk("R3 0x01 cmd", cmd_q, 8'h00);
    chk("R3 0x01 off", col_off, 12'h100);
    cmd(8'h50);
    chk("R3 0x50 small off", col_off, 512);
    cmd(8'h00);
    chk("R3 0x00 off", col_off, 0);
    do_reset(1, 0, 0);
    cmd(8'h50);
    chk("R3 0x50 large off", col_off, 2048);
    chk("R3 0x50 cmd", cmd_q, 8'h00);
  endtask

  task automatic t_small_read;
    do_reset(0, 0, 0);
    cmd(8'h00);
    adr(8'h12);
    chk("R6 cnt1", addr_cnt, 1);
    chk("R6 addr1", addr_q, 40'h12);
    adr(8'h34);
    chk("R9 no exec 2nd", exec_pulse, 0);
    adr(8'h56);
    chk("R6 addr3", addr_q, 40'h563412);
    chk("R9 exec 3rd", exec_pulse, 1);
    chk("R9 tag", exec_cmd, 8'h00);
    @(negedge clk);
    chk("R13 one cycle", exec_pulse, 0);
  endtask

  task automatic t_read_id;
    do_reset(0, 0, 0);
    cmd(8'h90);
    chk("R8 no exec on cmd", exec_pulse, 0);
    adr(8'h00);
    chk("R8 exec", exec_pulse, 1);
    chk("R8 tag", exec_cmd, 8'h90);
  endtask

  task automatic t_large_cycles;
    do_reset(1, 0, 0);
    cmd(8'h80);
    adr(8'h01); adr(8'h02); adr(8'h03);
    chk("R9 lp small cap 3rd", exec_pulse, 0);
    adr(8'h04);
    chk("R9 lp small cap 4th", exec_pulse, 1);
    chk("R9 lp tag", exec_cmd, 8'h80);
    do_reset(1, 1, 0);
    cmd(8'h00);
    adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04);
    chk("R9 lp big cap 4th", exec_pulse, 0);
    adr(8'h05);
    chk("R9 lp big cap 5th", exec_pulse, 1);
    chk("R9 lp big tag", exec_cmd, 8'h00);
  endtask

  task automatic t_x16;
    do_reset(0, 0, 1);
    cmd(8'h00);
    adr(8'h81);
    chk("R7 before shift", addr_q, 40'h81);
    adr(8'h02);
    chk("R7 shifted", addr_q, 40'h502);
    adr(8'h03);
    chk("R7 third byte", addr_q, 40'h030502);
  endtask

  task automatic t_saturate;
    do_reset(0, 0, 0);
    cmd(8'h85);
    for (int i = 1; i <= 8; i++) adr(8'(i));
    chk("R6 saturate cnt", addr_cnt, 7);
    chk("R6 extra dropped", addr_q, 40'h0504030201);
  endtask

  task automatic t_swallow;
    do_reset(1, 0, 0);
    cmd(8'h00);
    adr(8'hAA); adr(8'hBB);
    cmd(8'h30);
    chk("R4 cnt kept", addr_cnt, 2);
    chk("R4 cmd kept", cmd_q, 8'h00);
    chk("R4 no exec", exec_pulse, 0);
    chk("R4 addr kept", addr_q, 40'hBBAA);
    cmd(8'h80);
    cmd(8'h30);
    chk("R4 latched otherwise", cmd_q, 8'h30);
  endtask

  task automatic t_col_reset;
    do_reset(1, 0, 0);
    cmd(8'h00);
    adr(8'h11); adr(8'h22); adr(8'h33);
    cmd(8'h05);
    chk("R5 addr", addr_q, 40'h330000);
    chk("R5 cnt", addr_cnt, 0);
    chk("R5 cmd", cmd_q, 8'h00);
    chk("R5 no exec", exec_pulse, 0);
    adr(8'h44); adr(8'h55);
    cmd(8'hE0);
    chk("R10 E0 exec", exec_pulse, 1);
    chk("R10 E0 tag", exec_cmd, 8'hE0);
    chk("R10 E0 keeps cnt", addr_cnt, 2);
    chk("R6 addr after col", addr_q, 40'h335544);
  endtask

  task automatic t_immediate;
    do_reset(0, 0, 0);
    cmd(8'h00);
    adr(8'h01);
    cmd(8'h70);
    chk("R10 70 exec", exec_pulse, 1);
    chk("R10 70 tag", exec_cmd, 8'h70);
    chk("R10 70 clears cnt", addr_cnt, 0);
    cmd(8'h35);
    chk("R10 35 tag", exec_cmd, 8'h35);
    cmd(8'h80);
    chk("R10 80 not immediate", exec_pulse, 0);
  endtask

  task automatic t_erase(input logic lp, input logic [39:0] exp);
    do_reset(lp, 0, 0);
    cmd(8'h80);
    adr(8'h11); adr(8'h22); adr(8'h33); adr(8'h44);
    cmd(8'h60);
    chk("R10 60 exec", exec_pulse, 1);
    adr(8'hAB); adr(8'hCD);
    chk("R11 pre", addr_q, 40'h4433CDAB);
    cmd(8'hD0);
    chk("R11 masked shifted", addr_q, exp);
    chk("R11 exec tag", exec_cmd, 8'hD0);
    chk("R10 D0 cnt", addr_cnt, 0);
  endtask

  task automatic t_reset_cmd;
    do_reset(0, 0, 0);
    cmd(8'h01);
    adr(8'h77); adr(8'h66);
    cmd(8'hFF);
    chk("R12 cmd", cmd_q, 0);
    chk("R12 addr", addr_q, 0);
    chk("R12 off", col_off, 0);
    chk("R12 cnt", addr_cnt, 0);
    chk("R10 FF tag", exec_cmd, 8'hFF);
  endtask

  task automatic t_ignored;
    do_reset(0, 0, 0);
    cmd(8'h00);
    adr(8'h42);
    put(1'b1, 1'b0, 1'b1, 8'h70);
    chk("R2 ce high no exec", exec_pulse, 0);
    chk("R2 ce high cmd", cmd_q, 8'h00);
    put(1'b0, 1'b1, 1'b1, 8'h99);
    chk("R2 ce high addr", addr_q, 40'h42);
    put(1'b0, 1'b0, 1'b0, 8'h70);
    chk("R2 data byte cnt", addr_cnt, 1);
    chk("R2 data byte exec", exec_pulse, 0);
    put(1'b1, 1'b1, 1'b0, 8'h70);
    chk("R13 both high exec", exec_pulse, 1);
    chk("R13 both high cnt", addr_cnt, 0);
    chk("R13 both high addr", addr_q, 40'h42);
  endtask

  initial begin
    t_reset();
    t_aliases();
    t_small_read();
    t_read_id();
    t_large_cycles();
    t_x16();
    t_saturate();
    t_swallow();
    t_col_reset();
    t_immediate();
    t_erase(1'b0, 40'hCDAB00);
    t_erase(1'b1, 40'hCDAB0000);
    t_reset_cmd();
    t_ignored();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule